// File: doc/BRIEF.md
# SPI Rate Parameter Solver

This block turns a pair of frequencies into the settings of a two-stage serial clock prescaler. The first stage is a coarse power-of-two divider selected by a 2-bit field (`div`). The second stage is a fine divider selected by a 6-bit field (`brg`). A host presents the main clock frequency and the wanted serial clock frequency, both 32-bit values in hertz, and pulses `start`. The block then works through a short search and reports the fields with a one-cycle `done` pulse.

Internally, one iterative restoring divider forms `main / req`. The coarse stages are then tried in rising order, one per cycle. At each stage the integer quotient is cut down by a further factor of 4, 8, 16 or 32, and the result is compared against the legal window of the fine divider. A request that no setting can meet is pinned to the nearest end of the range and flagged as clamped. A request for zero hertz is refused with an error flag.

Top module: `spi_rate_solver`

## Requirements
- R1: After reset, `busy`, `done`, `clamped`, `err`, `div` and `brg` are all zero.
- R2: A `start` seen while idle makes `busy` high at the next clock edge. `busy` stays high until the edge that raises `done`, and it falls at that same edge.
- R3: With Q = floor(main/req) and C(d) = floor(Q / (4·2^d)), the result is the smallest `div` d in 0..3 for which C(d) lies in 5..64. In that case `brg` = C(d) − 1.
- R4: If C(d) is below 5 at the first stage tried, the result is `div` = 0, `brg` = 4 and `clamped` = 1. This covers req > main, where Q = 0.
- R5: If C(d) exceeds 64 for every d in 0..3, the result is `div` = 3, `brg` = 63 and `clamped` = 1.
- R6: A request with req = 0 completes with `err` = 1, `clamped` = 0, `div` = 0 and `brg` = 0.
- R7: `done` is high for exactly one cycle per accepted request. `div`, `brg`, `clamped` and `err` change only at the edge that raises `done`, and they hold their values until the next result.
- R8: A `start` that arrives while `busy` is high is ignored. The running request completes with its own operands, and no further result follows.
- R9: A result found inside the legal window has `clamped` = 0 and `err` = 0. This includes the edge values C = 5 (`brg` = 4) and C = 64 (`brg` = 63).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only while idle |
| main_hz | input | 32 | Main clock frequency, sampled with `start` |
| req_hz | input | 32 | Requested serial clock frequency, sampled with `start` |
| busy | output | 1 | High while a request is being solved |
| done | output | 1 | One-cycle result strobe |
| div | output | 2 | Coarse stage select; the pre-divide is 2·2^div |
| brg | output | 6 | Fine divider field; the divide is 2·(brg+1) |
| clamped | output | 1 | Request lay outside the reachable range and was pinned to an end |
| err | output | 1 | Request was refused because req was zero |

## Verification
The properties rely on the host pulsing `start` only while `busy` is low. If the host pulses it while busy, the block drops the pulse, so the properties still hold. The properties place no limit on operand values: every 32-bit pair, including zero divisors and divisors above the dividend, must give an in-range or flagged result. The stimulus respects the idle-start rule for every case it scores. It breaks that rule on purpose in exactly one case, a second `start` with different operands issued one cycle into a running solve. The operands are chosen so that Q lands on each window edge (19, 20, 259, 260, 2079, 2080), and the set also includes the largest dividend, a zero dividend and a zero divisor.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

   // Controller phases of the solver.
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LOAD,
      PH_DIVIDE,
      PH_SEARCH
   } solve_phase_t;

   // Outcome of evaluating one coarse stage.
   typedef enum logic [1:0] {
      VD_NEXT,   // candidate too large, try the next coarse stage
      VD_FIT,    // candidate inside the fine window
      VD_FAST,   // candidate below the window, pin to the low end
      VD_SLOW    // last stage still too large, pin to the high end
   } stage_verdict_t;

endpackage

// File: rtl/rs_udiv.sv
// Restoring unsigned divider, STEPS quotient bits per clock.
module rs_udiv #(
   parameter int W     = 32,
   parameter int STEPS = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] quotient,
   output logic         ready
);
   localparam int ITER  = W / STEPS;
   localparam int CNT_W = $clog2(ITER + 1);

   if (STEPS < 1 || (W % STEPS) != 0) begin : g_bad_steps
      $error("rs_udiv: STEPS must divide W");
   end

   logic [W-1:0]     rem_q;
   logic [W-1:0]     quo_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   logic [W-1:0] rem_c [STEPS+1];
   logic [W-1:0] quo_c [STEPS+1];

   assign rem_c[0] = rem_q;
   assign quo_c[0] = quo_q;

   for (genvar g = 0; g < STEPS; g++) begin : g_stage
      logic [W:0] trial;
      logic [W:0] diff;
      logic       fits;
      assign trial = {rem_c[g], quo_c[g][W-1]};
      assign diff  = trial - {1'b0, divisor};
      assign fits  = (trial >= {1'b0, divisor});
      assign rem_c[g+1] = fits ? diff[W-1:0] : trial[W-1:0];
      assign quo_c[g+1] = {quo_c[g][W-2:0], fits};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         ready <= 1'b0;
      end else if (go) begin
         rem_q <= '0;
         quo_q <= dividend;
         cnt_q <= CNT_W'(ITER);
         run_q <= 1'b1;
         ready <= 1'b0;
      end else if (run_q) begin
         rem_q <= rem_c[STEPS];
         quo_q <= quo_c[STEPS];
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) begin
            run_q <= 1'b0;
            ready <= 1'b1;
         end
      end else begin
         ready <= 1'b0;
      end
   end

   assign quotient = quo_q;

endmodule

// File: rtl/rs_step_eval.sv
// Classifies the candidate fine-divider value for one coarse stage.
module rs_step_eval
   import spi_rate_pkg::*;
#(
   parameter int W          = 32,
   parameter int DIV_W      = 2,
   parameter int BRG_W      = 6,
   parameter int BRG_MIN    = 4,
   parameter int BRG_MAX    = 63,
   parameter int SHIFT_BASE = 2
) (
   input  logic [W-1:0]     quo,
   input  logic [DIV_W-1:0] stage,
   output stage_verdict_t   verdict,
   output logic [BRG_W-1:0] brg_val
);
   localparam logic [W-1:0]     CAND_LO   = W'(BRG_MIN + 1);
   localparam logic [W-1:0]     CAND_HI   = W'(BRG_MAX + 1);
   localparam logic [DIV_W-1:0] LAST_STG  = {DIV_W{1'b1}};

   logic [W-1:0] cand;
   logic [W-1:0] cand_m1;

   assign cand    = quo >> (SHIFT_BASE + int'(stage));
   assign cand_m1 = cand - W'(1);

   always_comb begin
      if (cand < CAND_LO) begin
         verdict = VD_FAST;
         brg_val = BRG_W'(BRG_MIN);
      end else if (cand <= CAND_HI) begin
         verdict = VD_FIT;
         brg_val = cand_m1[BRG_W-1:0];
      end else if (stage == LAST_STG) begin
         verdict = VD_SLOW;
         brg_val = BRG_W'(BRG_MAX);
      end else begin
         verdict = VD_NEXT;
         brg_val = '0;
      end
   end

endmodule

// File: rtl/spi_rate_solver.sv
module spi_rate_solver
   import spi_rate_pkg::*;
#(
   parameter int FREQ_W     = 32,
   parameter int DIV_W      = 2,
   parameter int BRG_W      = 6,
   parameter int BRG_MIN    = 4,
   parameter int BRG_MAX    = 63,
   parameter int DIV_STEPS  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] main_hz,
   input  logic [FREQ_W-1:0] req_hz,
   output logic              busy,
   output logic              done,
   output logic [DIV_W-1:0]  div,
   output logic [BRG_W-1:0]  brg,
   output logic              clamped,
   output logic              err
);
   localparam int SHIFT_BASE = 2;

   if (BRG_MAX >= (1 << BRG_W) || BRG_MIN > BRG_MAX || BRG_MIN < 0) begin : g_bad_brg
      $error("spi_rate_solver: fine divider window does not fit BRG_W");
   end
   if (DIV_W < 1 || SHIFT_BASE + (1 << DIV_W) > FREQ_W) begin : g_bad_div
      $error("spi_rate_solver: coarse stage count too large for FREQ_W");
   end

   solve_phase_t      phase_q;
   logic [FREQ_W-1:0] main_q;
   logic [FREQ_W-1:0] req_q;
   logic [DIV_W-1:0]  stage_q;
   logic              go_q;

   logic [FREQ_W-1:0] quo;
   logic              quo_rdy;
   stage_verdict_t    verdict;
   logic [BRG_W-1:0]  brg_val;

   rs_udiv #(
      .W     (FREQ_W),
      .STEPS (DIV_STEPS)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go_q),
      .dividend (main_q),
      .divisor  (req_q),
      .quotient (quo),
      .ready    (quo_rdy)
   );

   rs_step_eval #(
      .W          (FREQ_W),
      .DIV_W      (DIV_W),
      .BRG_W      (BRG_W),
      .BRG_MIN    (BRG_MIN),
      .BRG_MAX    (BRG_MAX),
      .SHIFT_BASE (SHIFT_BASE)
   ) u_eval (
      .quo     (quo),
      .stage   (stage_q),
      .verdict (verdict),
      .brg_val (brg_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         main_q  <= '0;
         req_q   <= '0;
         stage_q <= '0;
         go_q    <= 1'b0;
         done    <= 1'b0;
         div     <= '0;
         brg     <= '0;
         clamped <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= 1'b0;
         go_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  main_q  <= main_hz;
                  req_q   <= req_hz;
                  phase_q <= PH_LOAD;
               end
            end
            PH_LOAD: begin
               if (req_q == '0) begin
                  div     <= '0;
                  brg     <= '0;
                  clamped <= 1'b0;
                  err     <= 1'b1;
                  done    <= 1'b1;
                  phase_q <= PH_IDLE;
               end else begin
                  go_q    <= 1'b1;
                  phase_q <= PH_DIVIDE;
               end
            end
            PH_DIVIDE: begin
               if (quo_rdy) begin
                  stage_q <= '0;
                  phase_q <= PH_SEARCH;
               end
            end
            PH_SEARCH: begin
               if (verdict == VD_NEXT) begin
                  stage_q <= stage_q + DIV_W'(1);
               end else begin
                  div     <= stage_q;
                  brg     <= brg_val;
                  clamped <= (verdict != VD_FIT);
                  err     <= 1'b0;
                  done    <= 1'b1;
                  phase_q <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/spi_rate_solver_chk.sv
module spi_rate_solver_chk #(
   parameter int FREQ_W  = 32,
   parameter int DIV_W   = 2,
   parameter int BRG_W   = 6,
   parameter int BRG_MIN = 4,
   parameter int BRG_MAX = 63
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [FREQ_W-1:0] main_hz,
   input logic [FREQ_W-1:0] req_hz,
   input logic              busy,
   input logic              done,
   input logic [DIV_W-1:0]  div,
   input logic [BRG_W-1:0]  brg,
   input logic              clamped,
   input logic              err
);
   localparam logic [DIV_W-1:0] LAST_STG = {DIV_W{1'b1}};

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R2
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(div) || !$stable(brg) || !$stable(clamped) || !$stable(err)) |-> done);

   // R3
   brg_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (brg >= BRG_W'(BRG_MIN) && brg <= BRG_W'(BRG_MAX)));

   // R6
   err_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (!clamped && div == '0 && brg == '0));

   // R4
   clamp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && clamped) |-> ((div == '0 && brg == BRG_W'(BRG_MIN)) ||
                             (div == LAST_STG && brg == BRG_W'(BRG_MAX))));

   // R8
   idle_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy || done));

   wire unused_ok = &{1'b0, start, main_hz, req_hz};

endmodule

bind spi_rate_solver spi_rate_solver_chk #(
   .FREQ_W  (FREQ_W),
   .DIV_W   (DIV_W),
   .BRG_W   (BRG_W),
   .BRG_MIN (BRG_MIN),
   .BRG_MAX (BRG_MAX)
) u_chk (.*);

// File: tb/sim_spi_rate_solver.sv
module sim_spi_rate_solver;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] main_hz = '0;
   logic [31:0] req_hz = '0;
   logic        busy, done, clamped, err;
   logic [1:0]  div;
   logic [5:0]  brg;

   int checks = 0;
   int fails  = 0;
   int extra_done = 0;
   bit finished = 0;

   logic [9:0] expq [$];
   logic [9:0] last_res = '0;
   logic       prev_done = 1'b0;

   always #2 clk = ~clk;

   spi_rate_solver u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .main_hz(main_hz), .req_hz(req_hz),
      .busy(busy), .done(done), .div(div), .brg(brg), .clamped(clamped), .err(err)
   );

   // Expected result packed as {err, clamped, div[1:0], brg[5:0]}.
   function automatic logic [9:0] model(input logic [31:0] m, input logic [31:0] r);
      logic [31:0] q, c;
      if (r == 0) return 10'b10_00_000000;
      q = m / r;
      for (int d = 0; d < 4; d++) begin
         c = q / (32'd4 << d);
         if (c < 5) return {1'b0, 1'b1, 2'(d), 6'd4};
         if (c <= 64) return {1'b0, 1'b0, 2'(d), 6'(c - 1)};
      end
      return {1'b0, 1'b1, 2'd3, 6'd63};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: scores each result as it appears.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done && prev_done) check(0, "R7 done longer than one cycle", 2, 1);
         if (done) begin
            if (expq.size() == 0) begin
               extra_done++;
            end else begin
               logic [9:0] e;
               e = expq.pop_front();
               last_res = {err, clamped, div, brg};
               check({err, clamped, div, brg} == e, "R3/R4/R5/R6/R9 result", {err, clamped, div, brg}, e);
            end
         end
         prev_done = done;
      end
   end

   // Driver: issues one request and queues its expected result.
   task automatic run_case(input logic [31:0] m, input logic [31:0] r, input bit poke_busy);
      while (busy) @(negedge clk);
      @(negedge clk);
      main_hz = m; req_hz = r; start = 1'b1;
      expq.push_back(model(m, r));
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      if (poke_busy) begin
         // R8: a second request while busy must not be taken
         main_hz = 32'd1000; req_hz = 32'd1; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (expq.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check({busy, done, clamped, err, div, brg} == '0, "R1 reset state",
            {busy, done, clamped, err, div, brg}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy, done, clamped, err, div, brg} == '0, "R1 idle after reset",
            {busy, done, clamped, err, div, brg}, 0);

      run_case(32'd100_000_000, 32'd1_000_000, 0); // R3 Q=100, div0 brg24
      run_case(32'd96_000_000, 32'd100_000, 0);    // R3 Q=960, div2 brg59
      run_case(32'd19, 32'd1, 0);                  // R4 C=4 fast clamp
      run_case(32'd5, 32'd10, 0);                  // R4 req above main
      run_case(32'd20, 32'd1, 0);                  // R9 C=5 lowest legal
      run_case(32'd259, 32'd1, 0);                 // R9 C=64 at div0
      run_case(32'd260, 32'd1, 0);                 // R3 moves to div1 brg31
      run_case(32'd2079, 32'd1, 0);                // R9 div3 brg63 unclamped
      run_case(32'd2080, 32'd1, 0);                // R5 slow clamp
      run_case(32'hFFFF_FFFF, 32'd1, 0);           // R5 largest dividend
      run_case(32'd48_000_000, 32'd0, 0);          // R6 zero request
      run_case(32'd0, 32'd7, 0);                   // R4 zero main clock
      run_case(32'd48_000_000, 32'd400_000, 1);    // R8 start while busy

      // R8: no result may follow the ignored start
      repeat (60) @(negedge clk);
      check(extra_done == 0 && busy == 1'b0, "R8 ignored start produced work", extra_done, 0);

      // R7: outputs hold after the result
      repeat (8) @(negedge clk);
      check({err, clamped, div, brg} == last_res, "R7 result held",
            {err, clamped, div, brg}, last_res);
      check(last_res == model(32'd48_000_000, 32'd400_000), "R8 result from first operands",
            last_res, model(32'd48_000_000, 32'd400_000));

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule